// File: doc/BRIEF.md
# Stack Segment Bounds Checker

This block decides whether a stack access is allowed under the current stack segment descriptor. The access is a push or a pop of 1 to 4 bytes at a given stack pointer. The CPU pipeline pulses a request strobe together with the access. One clock later the block reports a registered stack-fault flag and a 16-bit error code built from the stack selector. The exception sequencer then delivers the fault.

Outside protected mode nothing is checked. In protected mode there are two stages. A rights screen rejects a descriptor that is unusable, absent, of the wrong kind or read-only. A range rule then applies. The range rule differs for push and pop, and for expand-up and expand-down segments. It treats a zero pointer and a pointer at the top of the address range as special cases. All range arithmetic is one bit wider than the pointer, so no subtraction or addition wraps silently.

Top module: `stack_bounds_checker`

## Requirements
- R1: When the protected-mode flag is low, a request never raises the fault, whatever the descriptor and pointer are.
- R2: In protected mode, a request faults when the descriptor is marked not valid or not present.
- R3: In protected mode, a request faults when the descriptor is not a code/data descriptor (`dsc_codedata`=0), is a code segment (`dsc_code`=1), or is not writable.
- R4: The top bound U is 0x0000FFFF when `dsc_big`=0 and 0xFFFFFFFF when `dsc_big`=1. The range rules of R5 to R9 use this U.
- R5: An expand-down push (`dsc_expdown`=1, `is_pop`=0) faults when any of the following holds, where L is the length:
  - the pointer SP is 0
  - SP < L
  - SP − L ≤ limit
  - SP > U
- R6: An expand-up push with SP=0 faults unless the segment end equals U.
- R7: An expand-up push with SP≠0 faults when SP < L or when SP − 1 > limit.
- R8: An expand-down pop faults when SP = U or when (U − SP) + 1 < L. The sum is taken as a 33-bit unsigned value, so a negative result counts as large.
- R9: An expand-up pop faults when any of the following holds:
  - SP = U
  - the segment end is 0
  - SP > limit
  - (limit − SP) + 1 < L
- R10: When a request faults, `err_code` is loaded with the selector with bits 1:0 cleared (selector AND 0xFFFC). At all other times `err_code` holds its value.
- R11: `fault` is high only in the cycle right after a faulting request. It is low after a cycle with no request.
- R12: A synchronous active-high reset clears `fault` and `err_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | Check request strobe |
| prot_mode | input | 1 | Protected mode enabled |
| dsc_valid | input | 1 | Descriptor holds a usable entry |
| dsc_present | input | 1 | Segment present |
| dsc_codedata | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| dsc_code | input | 1 | 1 = code segment |
| dsc_writable | input | 1 | Segment writable |
| dsc_expdown | input | 1 | 1 = expand-down segment |
| dsc_big | input | 1 | Default size: 0 = 16-bit bound, 1 = 32-bit bound |
| dsc_limit | input | 32 | Segment limit |
| dsc_end | input | 32 | Segment end address |
| sp | input | 32 | Stack pointer |
| acc_len | input | 3 | Access length in bytes, 1 to 4 |
| is_pop | input | 1 | 1 = pop, 0 = push |
| stk_sel | input | 16 | Stack selector |
| fault | output | 1 | Stack fault, registered |
| err_code | output | 16 | Error code, registered |

## Verification
Both results are due at the first rising edge after the edge that sampled `chk_req`. The fault pulse falls again one edge later unless another request faults. The error code changes only at an edge that sampled a faulting request.

A behavioural reference in the bench reads the same inputs at each rising edge and schedules its expected values for that same edge. The comparison runs at every falling edge, while inputs and outputs are stable. Stimulus changes only on falling edges, after that comparison.

Each request is followed by an idle cycle. In that cycle the falling pulse and the held error code are checked.

// File: rtl/stk_chk_pkg.sv
package stk_chk_pkg;

    parameter int SP_W     = 32;  // stack pointer / limit width
    parameter int SEL_W    = 16;  // selector width
    parameter int LEN_W    = 3;   // access length field width
    parameter int NARROW_W = 16;  // bound width when default size is small
    parameter int RPL_W    = 2;   // low selector bits cleared in error code

    localparam int WIDE_W = SP_W + 1;

    typedef logic [SP_W-1:0]   sp_t;
    typedef logic [WIDE_W-1:0] wide_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // Access-rights part of the descriptor
    typedef struct packed {
        logic valid;
        logic present;
        logic codedata;
        logic is_code;
        logic writable;
    } stk_rights_t;

    // Range part of the descriptor
    typedef struct packed {
        logic expdown;
        sp_t  limit;
        sp_t  seg_end;
    } stk_span_t;

    typedef enum logic [1:0] {
        SCR_PASS   = 2'd0,
        SCR_ABSENT = 2'd1,
        SCR_KIND   = 2'd2
    } screen_t;

    function automatic wide_t widen(sp_t v);
        return {1'b0, v};
    endfunction

    function automatic wide_t widen_len(len_t l);
        return wide_t'(l);
    endfunction

    function automatic sp_t top_bound(logic big);
        sp_t ub;
        if (big) ub = '1;
        else     ub = {{(SP_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        return ub;
    endfunction

    function automatic sel_t strip_rpl(sel_t s);
        return {s[SEL_W-1:RPL_W], {RPL_W{1'b0}}};
    endfunction

endpackage

// File: rtl/stk_desc_screen.sv
module stk_desc_screen
    import stk_chk_pkg::*;
(
    input  stk_rights_t rights,
    output screen_t     verdict
);
    always_comb begin
        if (!rights.valid || !rights.present)
            verdict = SCR_ABSENT;
        else if (!rights.codedata || rights.is_code || !rights.writable)
            verdict = SCR_KIND;
        else
            verdict = SCR_PASS;
    end
endmodule

// File: rtl/stk_push_rule.sv
module stk_push_rule
    import stk_chk_pkg::*;
(
    input  stk_span_t span,
    input  sp_t       sp,
    input  len_t      len,
    input  sp_t       ub,
    output logic      bad
);
    wide_t w_sp, w_len, w_lim, w_ub, w_after, w_prev;
    logic  sp_zero, below_len, down_bad, up_zero_bad, up_bad;

    assign w_sp    = widen(sp);
    assign w_len   = widen_len(len);
    assign w_lim   = widen(span.limit);
    assign w_ub    = widen(ub);
    assign w_after = w_sp - w_len;
    assign w_prev  = w_sp - wide_t'(1);

    assign sp_zero   = (w_sp == '0);
    assign below_len = (w_sp < w_len);

    // expand-down: new top must land strictly above the limit, inside bound
    assign down_bad    = sp_zero || below_len || (w_after <= w_lim) || (w_sp > w_ub);
    // expand-up, pointer wrapped at zero: only legal if segment spans everything
    assign up_zero_bad = (span.seg_end != ub);
    // expand-up, normal: last byte pushed is sp-1 and must be within limit
    assign up_bad      = below_len || (w_prev > w_lim);

    always_comb begin
        if (span.expdown)  bad = down_bad;
        else if (sp_zero)  bad = up_zero_bad;
        else               bad = up_bad;
    end
endmodule

// File: rtl/stk_pop_rule.sv
module stk_pop_rule
    import stk_chk_pkg::*;
(
    input  stk_span_t span,
    input  sp_t       sp,
    input  len_t      len,
    input  sp_t       ub,
    output logic      bad
);
    wide_t w_sp, w_len, w_lim, w_ub, w_room_down, w_room_up;
    logic  at_top, down_bad, up_bad;

    assign w_sp   = widen(sp);
    assign w_len  = widen_len(len);
    assign w_lim  = widen(span.limit);
    assign w_ub   = widen(ub);

    // bytes available between pointer and the relevant top, inclusive
    assign w_room_down = (w_ub  - w_sp) + wide_t'(1);
    assign w_room_up   = (w_lim - w_sp) + wide_t'(1);

    assign at_top   = (w_sp == w_ub);
    assign down_bad = at_top || (w_room_down < w_len);
    assign up_bad   = at_top || (span.seg_end == '0) || (w_sp > w_lim)
                   || (w_room_up < w_len);

    assign bad = span.expdown ? down_bad : up_bad;
endmodule

// File: rtl/stack_bounds_checker.sv
module stack_bounds_checker
    import stk_chk_pkg::*;
#(
    parameter int P_SP_W  = stk_chk_pkg::SP_W,
    parameter int P_SEL_W = stk_chk_pkg::SEL_W,
    parameter int P_LEN_W = stk_chk_pkg::LEN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               chk_req,
    input  logic               prot_mode,
    input  logic               dsc_valid,
    input  logic               dsc_present,
    input  logic               dsc_codedata,
    input  logic               dsc_code,
    input  logic               dsc_writable,
    input  logic               dsc_expdown,
    input  logic               dsc_big,
    input  logic [P_SP_W-1:0]  dsc_limit,
    input  logic [P_SP_W-1:0]  dsc_end,
    input  logic [P_SP_W-1:0]  sp,
    input  logic [P_LEN_W-1:0] acc_len,
    input  logic               is_pop,
    input  logic [P_SEL_W-1:0] stk_sel,
    output logic               fault,
    output logic [P_SEL_W-1:0] err_code
);
    stk_rights_t rights;
    stk_span_t   span;
    screen_t     verdict;
    sp_t         ub;
    logic        push_bad, pop_bad, range_bad, hit;

    assign rights = '{valid: dsc_valid, present: dsc_present, codedata: dsc_codedata,
                      is_code: dsc_code, writable: dsc_writable};
    assign span   = '{expdown: dsc_expdown, limit: dsc_limit, seg_end: dsc_end};
    assign ub     = top_bound(dsc_big);

    stk_desc_screen u_screen (
        .rights  (rights),
        .verdict (verdict)
    );

    stk_push_rule u_push (
        .span (span),
        .sp   (sp),
        .len  (acc_len),
        .ub   (ub),
        .bad  (push_bad)
    );

    stk_pop_rule u_pop (
        .span (span),
        .sp   (sp),
        .len  (acc_len),
        .ub   (ub),
        .bad  (pop_bad)
    );

    assign range_bad = is_pop ? pop_bad : push_bad;
    assign hit       = chk_req && prot_mode && ((verdict != SCR_PASS) || range_bad);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault    <= 1'b0;
            err_code <= '0;
        end else begin
            fault <= hit;
            if (hit) err_code <= strip_rpl(stk_sel);
        end
    end

    p_real_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (chk_req && !prot_mode) |=> !fault);

    p_absent_r2: assert property (@(posedge clk) disable iff (rst)
        (chk_req && prot_mode && (!dsc_valid || !dsc_present)) |=> fault);

    p_kind_r3: assert property (@(posedge clk) disable iff (rst)
        (chk_req && prot_mode && (!dsc_codedata || dsc_code || !dsc_writable)) |=> fault);

    p_down_push_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (chk_req && prot_mode && dsc_expdown && !is_pop && (sp == '0)) |=> fault);

    p_up_pop_end_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (chk_req && prot_mode && !dsc_expdown && is_pop && (dsc_end == '0)) |=> fault);

    p_code_mask_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> (err_code[RPL_W-1:0] == '0));

    p_code_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !chk_req |=> $stable(err_code));

    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        !chk_req |=> !fault);
endmodule

// File: tb/stack_bounds_checker_test.sv
module stack_bounds_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chk_req = 1'b0, prot_mode = 1'b0;
    logic        dsc_valid = 1'b1, dsc_present = 1'b1, dsc_codedata = 1'b1;
    logic        dsc_code = 1'b0, dsc_writable = 1'b1, dsc_expdown = 1'b0, dsc_big = 1'b1;
    logic [31:0] dsc_limit = '0, dsc_end = '0, sp = '0;
    logic [2:0]  acc_len = 3'd1;
    logic        is_pop = 1'b0;
    logic [15:0] stk_sel = '0;
    logic        fault;
    logic [15:0] err_code;

    int    tests = 0, fails = 0, cyc = 0;
    bit    started = 1'b0, done = 1'b0;
    string cur_tag = "R12", exp_tag = "R12";
    logic        exp_fault = 1'b0;
    logic [15:0] exp_err = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_bounds_checker uut (
        .clk(clk), .rst(rst), .chk_req(chk_req), .prot_mode(prot_mode),
        .dsc_valid(dsc_valid), .dsc_present(dsc_present), .dsc_codedata(dsc_codedata),
        .dsc_code(dsc_code), .dsc_writable(dsc_writable), .dsc_expdown(dsc_expdown),
        .dsc_big(dsc_big), .dsc_limit(dsc_limit), .dsc_end(dsc_end), .sp(sp),
        .acc_len(acc_len), .is_pop(is_pop), .stk_sel(stk_sel),
        .fault(fault), .err_code(err_code)
    );

    // Behavioural reference written straight from the rules
    function automatic bit ref_bad();
        longint u, e, l, lim, t;
        if (!prot_mode) return 1'b0;
        if (!dsc_valid || !dsc_present) return 1'b1;
        if (!dsc_codedata || dsc_code || !dsc_writable) return 1'b1;
        u   = dsc_big ? 64'hFFFF_FFFF : 64'hFFFF;
        e   = longint'(sp);
        l   = longint'(acc_len);
        lim = longint'(dsc_limit);
        if (!is_pop) begin
            if (dsc_expdown) return (e == 0) || (e < l) || (e - l <= lim) || (e > u);
            if (e == 0)      return longint'(dsc_end) != u;
            return (e < l) || (e - 1 > lim);
        end
        if (dsc_expdown) begin
            t = u - e + 1;
            return (e == u) || (t >= 0 && t < l);
        end
        return (e == u) || (dsc_end == 0) || (e > lim) || (lim - e + 1 < l);
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        exp_tag <= cur_tag;
        if (rst) begin
            exp_fault <= 1'b0;
            exp_err   <= '0;
        end else begin
            exp_fault <= chk_req && ref_bad();
            if (chk_req && ref_bad()) exp_err <= stk_sel & 16'hFFFC;
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            tests++;
            if (fault !== exp_fault || err_code !== exp_err) begin
                fails++;
                $display("FAIL %s: fault=%0b err_code=%h, expected fault=%0b err_code=%h",
                         exp_tag, fault, err_code, exp_fault, exp_err);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: cycle=%0d, expected completion before %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic set_desc(bit ed, bit big, logic [31:0] lim, logic [31:0] en);
        dsc_valid = 1; dsc_present = 1; dsc_codedata = 1; dsc_code = 0; dsc_writable = 1;
        dsc_expdown = ed; dsc_big = big; dsc_limit = lim; dsc_end = en;
    endtask

    // one request cycle, then one idle cycle (pulse fall and code hold, R10 R11)
    task automatic fire(string tag, logic [31:0] p, int len, bit pop, logic [15:0] sel);
        @(negedge clk);
        cur_tag = tag; chk_req = 1; sp = p; acc_len = 3'(len); is_pop = pop; stk_sel = sel;
        @(negedge clk);
        cur_tag = "R10 R11 idle"; chk_req = 0; stk_sel = ~sel;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: real mode ignores even a broken descriptor
        prot_mode = 0; set_desc(1, 0, 32'h0, 32'h0); dsc_valid = 0; dsc_writable = 0;
        fire("R1", 32'h0, 4, 0, 16'h1111);
        fire("R1", 32'hFFFF, 4, 1, 16'h2222);
        prot_mode = 1;

        // R2
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF); dsc_valid = 0;
        fire("R2", 32'h100, 2, 0, 16'h1237);
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF); dsc_present = 0;
        fire("R2", 32'h100, 2, 1, 16'h4C5A);
        // R3
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF); dsc_codedata = 0;
        fire("R3", 32'h100, 2, 0, 16'h0013);
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF); dsc_code = 1;
        fire("R3", 32'h100, 2, 1, 16'hABCF);
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF); dsc_writable = 0;
        fire("R3", 32'h100, 2, 0, 16'h8002);
        // legal baseline
        set_desc(0, 1, 32'hFFFF, 32'hFFFF_FFFF);
        fire("R7", 32'h100, 2, 0, 16'h0101);

        // R4: bound depends on default size
        set_desc(1, 0, 32'h0, 32'h0);
        fire("R4 R8", 32'h0000_FFFF, 2, 1, 16'h3003);
        set_desc(1, 1, 32'h0, 32'h0);
        fire("R4 R8", 32'h0000_FFFF, 2, 1, 16'h3007);
        fire("R4 R8", 32'hFFFF_FFFF, 1, 1, 16'h300B);

        // R5: expand-down push
        set_desc(1, 1, 32'h0FFF, 32'h0);
        fire("R5 zero", 32'h0, 4, 0, 16'h5001);
        fire("R5 below", 32'h2, 4, 0, 16'h5002);
        fire("R5 limit", 32'h1002, 4, 0, 16'h5003);
        fire("R5 ok", 32'h1004, 4, 0, 16'h5004);
        set_desc(1, 0, 32'h0FFF, 32'h0);
        fire("R5 over", 32'h0001_0000, 4, 0, 16'h5005);

        // R6: expand-up push at zero
        set_desc(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        fire("R6 full", 32'h0, 4, 0, 16'h6001);
        set_desc(0, 1, 32'hFFFF_FFFE, 32'hFFFF_FFFE);
        fire("R6 short", 32'h0, 4, 0, 16'h6002);
        set_desc(0, 0, 32'hFFFF, 32'hFFFF);
        fire("R6 small", 32'h0, 2, 0, 16'h6003);
        set_desc(0, 0, 32'hFFFF, 32'hFFFF_FFFF);
        fire("R6 mism", 32'h0, 2, 0, 16'h6004);

        // R7: expand-up push, nonzero pointer
        set_desc(0, 1, 32'h07FF, 32'h07FF);
        fire("R7 edge", 32'h800, 4, 0, 16'h7001);
        fire("R7 over", 32'h801, 4, 0, 16'h7002);
        fire("R7 below", 32'h3, 4, 0, 16'h7003);
        fire("R7 exact", 32'h4, 4, 0, 16'h7004);

        // R8: expand-down pop
        set_desc(1, 0, 32'h0100, 32'h0);
        fire("R8 room", 32'hFFFE, 4, 1, 16'h8001);
        fire("R8 fits", 32'hFFFE, 2, 1, 16'h8002);
        fire("R8 wrap", 32'h0001_0000, 1, 1, 16'h8003);

        // R9: expand-up pop
        set_desc(0, 1, 32'h00FF, 32'h1000);
        fire("R9 fits", 32'hFC, 4, 1, 16'h9001);
        fire("R9 short", 32'hFD, 4, 1, 16'h9002);
        fire("R9 over", 32'h100, 1, 1, 16'h9003);
        set_desc(0, 1, 32'h00FF, 32'h0);
        fire("R9 end0", 32'h10, 1, 1, 16'h9004);
        set_desc(0, 0, 32'hFFFF, 32'hFFFF);
        fire("R9 top", 32'hFFFF, 1, 1, 16'h9005);

        // R10 R11: back-to-back requests without idle gap
        set_desc(0, 1, 32'h07FF, 32'h07FF);
        @(negedge clk); cur_tag = "R10 R11 b2b"; chk_req = 1; sp = 32'h801; acc_len = 4; is_pop = 0; stk_sel = 16'hBEEF;
        @(negedge clk); sp = 32'h100; stk_sel = 16'h1234;
        @(negedge clk); sp = 32'h900; stk_sel = 16'h4321;
        @(negedge clk); chk_req = 0;

        // mixed patterns across all range rules (R5 R6 R7 R8 R9)
        for (int i = 0; i < 300; i++) begin
            set_desc($urandom_range(0, 1), $urandom_range(0, 1),
                     ($urandom_range(0, 3) == 0) ? 32'hFFFF : 32'($urandom_range(0, 32'h3_0000)),
                     ($urandom_range(0, 3) == 0) ? 32'h0 : 32'hFFFF_FFFF);
            fire("R5 R6 R7 R8 R9 mix",
                 ($urandom_range(0, 7) == 0) ? 32'h0 : 32'($urandom_range(0, 32'h3_0000)),
                 $urandom_range(1, 4), $urandom_range(0, 1), 16'($urandom));
        end

        // R12: reset mid-run clears outputs
        set_desc(0, 1, 32'h0, 32'h0); dsc_valid = 0;
        @(negedge clk); cur_tag = "R12"; chk_req = 1; stk_sel = 16'hFFFF;
        @(negedge clk); chk_req = 0; rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule